// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static Memory Model

This block is a synthesizable stand-in for an asynchronous static memory with a 16-bit data path split into a lower and an upper byte lane. It has two chip selects of opposite polarity, an output enable, a write enable and one enable per byte lane. These pins set the mode of each lane: idle, muted, read or write. A fast sample clock stands in for the level-sensitive timing of the real part, so the model can sit in a clocked simulation or on an emulation fabric.

Reads are combinational from the array at the present address. An undriven lane returns zero on the read bus. Its per-lane drive flag is exported in place of a true tri-state. A write does not take effect on a clock edge. It is held open while the chip is selected, write enable is low and at least one byte lane is enabled. It commits when that condition ends, using the address, data and lane mask seen in the last sample in which it was still active. The address width is a parameter; the default of 10 bits keeps the array small.

Top module: `bslsram_top`

## Requirements
- R1: The chip is selected only when `cs_a_n` is 0 and `cs_b` is 1. In every other case both lane drive flags are 0, whatever the other pins are.
- R2: With both `lo_en_n` and `hi_en_n` at 1, both lanes are undriven even when the chip is selected, and a write held open ends there.
- R3: Selected with `wr_n` = 1 and `rd_n` = 1 (muted mode), both lanes are undriven and the array is not accessed.
- R4: Selected with `wr_n` = 1 and `rd_n` = 0, the lower lane drives `rdata[7:0]` from the lower byte at `addr` when `lo_en_n` is 0. The upper lane drives `rdata[15:8]` from the upper byte when `hi_en_n` is 0.
- R5: A lane whose drive flag is 0 presents zero on its half of `rdata`.
- R6: Selected with `wr_n` = 0 is a write whatever `rd_n` is, and both lanes stay undriven for its whole length.
- R7: A write commits once, on the sample edge at which the write condition first becomes false. The condition can end through `wr_n` rising, `cs_a_n` rising or `cs_b` falling. Only the lanes enabled in the last active sample are changed; the other lane keeps its contents.
- R8: If the address or data change while a write is held, only the values of the last active sample are stored.
- R9: After reset every location reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset; clears the array |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| lo_en_n | input | 1 | Lower byte lane enable, active low |
| hi_en_n | input | 1 | Upper byte lane enable, active low |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data, lower byte in bits 7:0 |
| rdata | output | 16 | Read data, zero on undriven lanes |
| lane_lo_drv | output | 1 | Lower lane is driving |
| lane_hi_drv | output | 1 | Upper lane is driving |

## Verification
The assertions check every sample for the floating rules: deselect, no lane enabled, muted mode and any write all keep both drive flags low. They also check that an undriven lane shows zero, that a read with a lane enabled drives it, and that a commit happens only on the falling edge of the write condition and never twice in a row. The contents of the array can only be shown by the bench scenarios. These cover the byte masks, each of the ways a write can end, address and data changes during a held write, and the all-zero state after reset.

// File: rtl/bslsram_pkg.sv
package bslsram_pkg;

  localparam int NLANES = 2;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_MUTE  = 2'd1,
    MD_READ  = 2'd2,
    MD_WRITE = 2'd3
  } mode_e;

  // Both selects must agree for the chip to respond.
  function automatic logic chip_on(input logic sel_lo_n, input logic sel_hi);
    return !sel_lo_n && sel_hi;
  endfunction

  // Bit 0 is the lower byte lane, bit 1 the upper.
  function automatic logic [NLANES-1:0] lane_pick(input logic lo_n, input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

endpackage

// File: rtl/bslsram_decode.sv
module bslsram_decode
  import bslsram_pkg::*;
(
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              lo_en_n,
  input  logic              hi_en_n,
  output mode_e             mode,
  output logic [NLANES-1:0] lanes,
  output logic [NLANES-1:0] drive,
  output logic              wcond
);

  always_comb begin
    lanes = lane_pick(lo_en_n, hi_en_n);
    if (!chip_on(cs_a_n, cs_b) || (lanes == '0)) begin
      mode = MD_IDLE;
    end else if (!wr_n) begin
      mode = MD_WRITE;
    end else if (!rd_n) begin
      mode = MD_READ;
    end else begin
      mode = MD_MUTE;
    end
    drive = (mode == MD_READ) ? lanes : '0;
    wcond = (mode == MD_WRITE);
  end

endmodule

// File: rtl/bslsram_wtrack.sv
module bslsram_wtrack #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wcond,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NL-1:0] lanes,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data,
  output logic [NL-1:0] c_mask
);

  logic was_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_on <= 1'b0;
      c_addr <= '0;
      c_data <= '0;
      c_mask <= '0;
    end else begin
      was_on <= wcond;
      if (wcond) begin
        c_addr <= addr;
        c_data <= wdata;
        c_mask <= lanes;
      end
    end
  end

  // The write closes in the first sample where its condition is gone.
  assign commit = was_on && !wcond;

endmodule

// File: rtl/bslsram_lane.sv
module bslsram_lane #(
  parameter int AW = 10,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [BW-1:0] wbyte,
  input  logic [AW-1:0] raddr,
  input  logic          drive,
  output logic [BW-1:0] rbyte
);

  localparam int DEPTH = 1 << AW;

  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (wr_en) begin
      mem[waddr] <= wbyte;
    end
  end

  assign rbyte = drive ? mem[raddr] : '0;

endmodule

// File: rtl/bslsram_top.sv
module bslsram_top
  import bslsram_pkg::*;
#(
  parameter int AW = 10,
  parameter int BW = 8,
  localparam int DW = BW * NLANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_a_n,
  input  logic          cs_b,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          lo_en_n,
  input  logic          hi_en_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          lane_lo_drv,
  output logic          lane_hi_drv
);

  mode_e             mode;
  logic [NLANES-1:0] lanes;
  logic [NLANES-1:0] drive;
  logic              wcond;
  logic              commit;
  logic [AW-1:0]     c_addr;
  logic [DW-1:0]     c_data;
  logic [NLANES-1:0] c_mask;

  bslsram_decode dec_i (
    .cs_a_n  (cs_a_n),
    .cs_b    (cs_b),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .lo_en_n (lo_en_n),
    .hi_en_n (hi_en_n),
    .mode    (mode),
    .lanes   (lanes),
    .drive   (drive),
    .wcond   (wcond)
  );

  bslsram_wtrack #(.AW(AW), .DW(DW), .NL(NLANES)) trk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wcond  (wcond),
    .addr   (addr),
    .wdata  (wdata),
    .lanes  (lanes),
    .commit (commit),
    .c_addr (c_addr),
    .c_data (c_data),
    .c_mask (c_mask)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    bslsram_lane #(.AW(AW), .BW(BW)) lane_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (commit && c_mask[g]),
      .waddr (c_addr),
      .wbyte (c_data[g*BW +: BW]),
      .raddr (addr),
      .drive (drive[g]),
      .rbyte (rdata[g*BW +: BW])
    );
  end

  assign lane_lo_drv = drive[0];
  assign lane_hi_drv = drive[1];

endmodule

// File: rtl/bslsram_chk.sv
module bslsram_chk
  import bslsram_pkg::*;
#(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_a_n,
  input logic            cs_b,
  input logic            rd_n,
  input logic            wr_n,
  input logic            lo_en_n,
  input logic            hi_en_n,
  input logic            lo_drv,
  input logic            hi_drv,
  input logic [2*BW-1:0] rdata,
  input mode_e           mode,
  input logic            wcond,
  input logic            commit
);

  // R1
  desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n || !cs_b) |-> (!lo_drv && !hi_drv));

  // R2
  nolane_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_en_n && hi_en_n) |-> (!lo_drv && !hi_drv && !wcond));

  // R3
  muted_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_MUTE) |-> (!lo_drv && !hi_drv && rd_n && wr_n));

  // R4
  read_lo_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_a_n && cs_b && wr_n && !rd_n && !lo_en_n) |-> lo_drv);

  // R4
  read_hi_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_a_n && cs_b && wr_n && !rd_n && !hi_en_n) |-> hi_drv);

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_drv |-> (rdata[BW-1:0] == '0)) and (!hi_drv |-> (rdata[2*BW-1:BW] == '0)));

  // R6
  write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcond |-> (!lo_drv && !hi_drv && !wr_n));

  // R7
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!wcond && $past(wcond)));

  // R7
  commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

bind bslsram_top bslsram_chk #(.BW(BW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_a_n  (cs_a_n),
  .cs_b    (cs_b),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .lo_en_n (lo_en_n),
  .hi_en_n (hi_en_n),
  .lo_drv  (lane_lo_drv),
  .hi_drv  (lane_hi_drv),
  .rdata   (rdata),
  .mode    (mode),
  .wcond   (wcond),
  .commit  (commit)
);

// File: tb/bslsram_top_tb_top.sv
`timescale 1ns/1ps
module bslsram_top_tb_top;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_a_n = 1'b1, cs_b = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic          lo_en_n = 1'b1, hi_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          lane_lo_drv, lane_hi_drv;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bslsram_top #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .rd_n(rd_n), .wr_n(wr_n),
    .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_lo_drv(lane_lo_drv), .lane_hi_drv(lane_hi_drv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    cs_a_n = 1'b1; cs_b = 1'b1; rd_n = 1'b1; wr_n = 1'b1; lo_en_n = 1'b1; hi_en_n = 1'b1;
  endtask

  // endby: 0 write enable rises, 1 active-low select rises, 2 active-high select falls
  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic lo_n,
                          input logic hi_n, input logic oen, input int endby);
    @(negedge clk);
    addr = a; wdata = d; lo_en_n = lo_n; hi_en_n = hi_n; rd_n = oen;
    cs_a_n = 1'b0; cs_b = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    check("R6 lanes float during write", {lane_hi_drv, lane_lo_drv}, 2'b00);
    @(negedge clk);
    case (endby)
      0: wr_n = 1'b1;
      1: cs_a_n = 1'b1;
      default: cs_b = 1'b0;
    endcase
    @(negedge clk);
    go_idle();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic lo_n, input logic hi_n,
                         input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a; lo_en_n = lo_n; hi_en_n = hi_n; cs_a_n = 1'b0; cs_b = 1'b1;
    wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    check(req, rdata, exp);
    check("R4 lane drive flags", {lane_hi_drv, lane_lo_drv}, {~hi_n, ~lo_n});
    go_idle();
  endtask

  task automatic t_reset_state();
    check("R1 idle after reset, no drive", {lane_hi_drv, lane_lo_drv}, 2'b00);
    check("R5 idle rdata zero", rdata, 16'h0000);
    do_read(10'd0, 1'b0, 1'b0, 16'h0000, "R9 addr 0 zero");
    do_read(10'd5, 1'b0, 1'b0, 16'h0000, "R9 addr 5 zero");
    do_read(10'd1023, 1'b0, 1'b0, 16'h0000, "R9 top addr zero");
  endtask

  task automatic t_word_write();
    do_write(10'd3, 16'h1234, 1'b0, 1'b0, 1'b1, 0);
    do_read(10'd3, 1'b0, 1'b0, 16'h1234, "R7 word write ended by write enable");
  endtask

  task automatic t_byte_writes();
    // lower only, output enable low during the write, ended by active-low select
    do_write(10'd3, 16'hAB55, 1'b0, 1'b1, 1'b0, 1);
    do_read(10'd3, 1'b0, 1'b0, 16'h1255, "R7 lower only, upper kept (R6 rd_n ignored)");
    // upper only, ended by active-high select
    do_write(10'd3, 16'h9A77, 1'b1, 1'b0, 1'b1, 2);
    do_read(10'd3, 1'b0, 1'b0, 16'h9A55, "R7 upper only ended by cs_b");
  endtask

  task automatic t_byte_reads();
    do_read(10'd3, 1'b0, 1'b1, 16'h0055, "R4 R5 lower read, upper zero");
    do_read(10'd3, 1'b1, 1'b0, 16'h9A00, "R4 R5 upper read, lower zero");
  endtask

  task automatic t_float();
    @(negedge clk);
    addr = 10'd3; wr_n = 1'b1; rd_n = 1'b0; lo_en_n = 1'b0; hi_en_n = 1'b0;
    cs_a_n = 1'b1; cs_b = 1'b1;
    @(negedge clk);
    check("R1 cs_a_n high floats", {lane_hi_drv, lane_lo_drv, rdata}, 18'h0);
    cs_a_n = 1'b0; cs_b = 1'b0;
    @(negedge clk);
    check("R1 cs_b low floats", {lane_hi_drv, lane_lo_drv, rdata}, 18'h0);
    cs_b = 1'b1; lo_en_n = 1'b1; hi_en_n = 1'b1;
    @(negedge clk);
    check("R2 no lane enabled floats", {lane_hi_drv, lane_lo_drv, rdata}, 18'h0);
    lo_en_n = 1'b0; hi_en_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    check("R3 muted floats", {lane_hi_drv, lane_lo_drv, rdata}, 18'h0);
    rd_n = 1'b0;
    @(negedge clk);
    check("R4 full read after muted", rdata, 16'h9A55);
    go_idle();
    do_read(10'd3, 1'b0, 1'b0, 16'h9A55, "R3 muted left array intact");
  endtask

  task automatic t_last_sample();
    @(negedge clk);
    addr = 10'd7; wdata = 16'h1111; lo_en_n = 1'b0; hi_en_n = 1'b0;
    cs_a_n = 1'b0; cs_b = 1'b1; wr_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    addr = 10'd8; wdata = 16'h2222;
    @(negedge clk);
    hi_en_n = 1'b1; wdata = 16'h3333;
    @(negedge clk);
    check("R6 lanes float in held write", {lane_hi_drv, lane_lo_drv}, 2'b00);
    lo_en_n = 1'b1;
    @(negedge clk);
    go_idle();
    do_read(10'd8, 1'b0, 1'b0, 16'h0033, "R8 last sample addr, data and mask (R2 end)");
    do_read(10'd7, 1'b0, 1'b0, 16'h0000, "R8 earlier address untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_word_write();
    t_byte_writes();
    t_byte_reads();
    t_float();
    t_last_sample();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule